// File: doc/BRIEF.md
# Dual-Channel Serial Converter Host Controller

This block is the host-side master for a two-input, 12-bit successive-approximation converter that is reached over a four-wire serial link. The link has an active-low select, a serial clock, a host-to-converter data line and a converter-to-host data line. The controller runs from the system clock. It makes the serial clock with a divider, so each half period of the serial clock lasts `DIV_HALF` system clocks. One select-low frame carries one to `MAX_BURST` back-to-back 16-clock conversions.

In every conversion the controller sends an 8-bit control byte. Its channel bit picks the input for the *following* conversion, not for the current one. So the controller keeps a record of the last channel it asked for and tags each received result with it. After reset this record starts at channel 1. The host starts a frame with a one-cycle `start` pulse. It gives the conversion count minus one on `burst_cnt` and the per-conversion channel requests on `chan_seq`. It then waits for `done`. Each 12-bit result comes out with a one-cycle `res_valid` strobe.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset `cs_n` and `sclk` are 1, and `busy`, `done` and `res_valid` are 0.
- R2: `sclk` is 1 whenever `cs_n` is 1. A frame contains exactly 16*(`burst_cnt`+1) rising `sclk` edges. `cs_n` rises only after the last of them.
- R3: While `cs_n` is low, `sclk` toggles every `DIV_HALF` system clocks. The first falling edge comes `DIV_HALF` clocks after `cs_n` falls.
- R4: On each conversion's first 8 rising edges `din` carries the control byte, MSB first. Byte bit 3 is the channel (0 = channel 1, 1 = channel 2). All other bits are 0, and bit 4 is never 1. `din` changes only on falling `sclk` edges.
- R5: Conversion j of a frame (j = 0..`burst_cnt`) sends `chan_seq[j]` as its channel bit.
- R6: `dout` is sampled on rising `sclk` edges. The first 4 bits of each 16-bit word are dropped, and the last 12 form `res_data`, MSB first. `res_valid` is a one-cycle pulse in the cycle after each conversion's 16th rising edge.
- R7: `res_chan` is the channel bit sent during the previous conversion, and this carries across frames. The first result after reset is tagged 0 (channel 1).
- R8: `busy` is 1 from the cycle after an accepted `start` until the frame ends. `done` is a one-cycle pulse in the same cycle that `cs_n` returns high and `busy` falls.
- R9: A `start` pulse while `busy` is 1 is ignored. The running frame keeps its count and channels, and no further frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| burst_cnt | input | IDX_W | Conversions in the frame minus one |
| chan_seq | input | MAX_BURST | Channel bit sent in conversion j is bit j |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| res_valid | output | 1 | Result strobe |
| res_data | output | 12 | Conversion result, straight binary |
| res_chan | output | 1 | Channel of res_data (0 = channel 1) |
| cs_n | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock, idles high |
| din | output | 1 | Control byte to the converter |
| dout | input | 1 | Serial data from the converter |

## Verification
A behavioural converter model in the bench decodes the control byte on rising edges and answers on falling edges. It converts the channel that was requested one conversion earlier. The bench drives a single-conversion frame right after reset, to show that the first result is tagged channel 1. It drives a full eight-conversion burst with a mixed channel pattern, to catch wrong bit ordering or off-by-one tagging. It drives an all-channel-1 frame, and a frame that a `start` pulse tries to disturb while it runs. Data patterns include all-zeros and all-ones results. The dropped leading bits are driven high, so a shift that keeps the wrong 12 bits would show.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    localparam int WORD_BITS = 16;
    localparam int DATA_BITS = 12;
    localparam int CTRL_BITS = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TAIL = 2'd2
    } host_state_e;

    // Control byte: only bit 3 (channel) may be set; bit 4 must stay 0.
    function automatic logic [CTRL_BITS-1:0] make_ctrl(input logic ch);
        return {2'b00, 1'b0, 1'b0, ch, 3'b000};
    endfunction

endpackage

// File: rtl/adc_host_divider.sv
module adc_host_divider #(
    parameter int DIV_HALF = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/adc_host_capture.sv
module adc_host_capture
    import adc_host_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample,
    input  logic                 last,
    input  logic                 dout,
    output logic                 valid,
    output logic [DATA_BITS-1:0] data
);
    typedef struct packed {
        logic [WORD_BITS-1:0] sh;
        logic                 valid;
        logic [DATA_BITS-1:0] data;
    } cap_t;

    cap_t d, q;
    logic [WORD_BITS-1:0] sh_next;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        sh_next = {q.sh[WORD_BITS-2:0], dout};
        if (sample) begin
            d.sh = sh_next;
            if (last) begin
                d.valid = 1'b1;
                d.data  = sh_next[DATA_BITS-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign valid = q.valid;
    assign data  = q.data;

endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int DIV_HALF  = 16,
    parameter int MAX_BURST = 8,
    localparam int IDX_W    = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [IDX_W-1:0]     burst_cnt,
    input  logic [MAX_BURST-1:0] chan_seq,
    output logic                 busy,
    output logic                 done,
    output logic                 res_valid,
    output logic [DATA_BITS-1:0] res_data,
    output logic                 res_chan,
    output logic                 cs_n,
    output logic                 sclk,
    output logic                 din,
    input  logic                 dout
);
    localparam int PH_W  = $clog2(2 * WORD_BITS);
    localparam int BIT_W = PH_W - 1;

    typedef struct packed {
        host_state_e          st;
        logic [PH_W-1:0]      phase;
        logic [IDX_W-1:0]     idx;
        logic [IDX_W-1:0]     last_idx;
        logic [MAX_BURST-1:0] seq;
        logic                 sclk;
        logic                 cs_n;
        logic                 din;
        logic                 prev_addr;
        logic                 tag;
        logic                 done;
    } regs_t;

    regs_t d, q;

    logic                 tick;
    logic                 cur_ch;
    logic [BIT_W-1:0]     bit_no;
    logic [CTRL_BITS-1:0] ctl_sh;
    logic                 word_end;
    logic                 cap_sample;

    adc_host_divider #(.DIV_HALF(DIV_HALF)) i_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.st != ST_IDLE),
        .tick (tick)
    );

    assign cur_ch     = q.seq[q.idx];
    assign bit_no     = q.phase[PH_W-1:1];
    assign ctl_sh     = make_ctrl(cur_ch) << bit_no;
    assign word_end   = (q.phase == '1);
    assign cap_sample = tick && (q.st == ST_RUN) && !q.sclk;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st       = ST_RUN;
                    d.cs_n     = 1'b0;
                    d.phase    = '0;
                    d.idx      = '0;
                    d.last_idx = burst_cnt;
                    d.seq      = chan_seq;
                    d.din      = 1'b0;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    d.phase = q.phase + 1'b1;
                    if (q.sclk) begin
                        d.sclk = 1'b0;
                        d.din  = ctl_sh[CTRL_BITS-1];
                    end else begin
                        d.sclk = 1'b1;
                        if (word_end) begin
                            d.tag       = q.prev_addr;
                            d.prev_addr = cur_ch;
                            if (q.idx == q.last_idx) begin
                                d.st = ST_TAIL;
                            end else begin
                                d.idx = q.idx + 1'b1;
                            end
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    d.cs_n = 1'b1;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.sclk <= 1'b1;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    adc_host_capture i_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .sample(cap_sample),
        .last  (word_end),
        .dout  (dout),
        .valid (res_valid),
        .data  (res_data)
    );

    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign res_chan = q.tag;
    assign cs_n     = q.cs_n;
    assign sclk     = q.sclk;
    assign din      = q.din;

endmodule

// File: rtl/adc_host_checker.sv
module adc_host_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic din,
    input logic busy,
    input logic done,
    input logic res_valid
);
    logic        sclk_prev;
    logic [3:0]  fall_pos;
    logic [15:0] rise_total;
    logic        fall_now;
    logic        rise_now;

    assign fall_now = sclk_prev && !sclk && !cs_n;
    assign rise_now = !sclk_prev && sclk && !cs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev  <= 1'b1;
            fall_pos   <= '0;
            rise_total <= '0;
        end else begin
            sclk_prev <= sclk;
            if (cs_n) begin
                fall_pos   <= '0;
                rise_total <= '0;
            end else begin
                if (fall_now) fall_pos <= fall_pos + 1'b1;
                if (rise_now) rise_total <= rise_total + 1'b1;
            end
        end
    end

    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    a_r2_whole_words: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (rise_total != 16'd0) && (rise_total[3:0] == 4'd0));

    a_r4_add1_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_now && fall_pos == 4'd3) |-> !din);

    a_r4_din_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$stable(din)) |-> fall_now);

    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n && $rose(cs_n)));

endmodule

bind adc_host_ctrl adc_host_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .din      (din),
    .busy     (busy),
    .done     (done),
    .res_valid(res_valid)
);

// File: tb/test_adc_host_ctrl.sv
module test_adc_host_ctrl;
    localparam int HALF = 4;
    localparam int MAXB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  burst_cnt = '0;
    logic [7:0]  chan_seq = '0;
    logic        busy, done, res_valid, res_chan, cs_n, sclk, din;
    logic [11:0] res_data;
    logic        dout = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    adc_host_ctrl #(.DIV_HALF(HALF), .MAX_BURST(MAXB)) i_adc_host_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .burst_cnt(burst_cnt),
        .chan_seq(chan_seq), .busy(busy), .done(done), .res_valid(res_valid),
        .res_data(res_data), .res_chan(res_chan), .cs_n(cs_n), .sclk(sclk),
        .din(din), .dout(dout)
    );

    task automatic chk(input bit ok, input string req, input string info);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, info);
        end
    endtask

    // ---------------- converter model ----------------
    bit          exp_addr[$];
    logic [12:0] exp_res[$];
    int          fall_cnt = 0, rise_cnt = 0, conv_no = 0, frame_rises = 0;
    bit          frame_open = 0;
    logic        conv_ch = 1'b0, latched = 1'b0;
    logic [11:0] cur_val = '0;
    logic [7:0]  ctl = '0;

    function automatic logic [11:0] gen(input int n, input logic ch);
        if (n == 3) return 12'hFFF;
        if (n == 4) return 12'h000;
        return 12'((n * 371 + (ch ? 1000 : 0) + 5) & 12'hFFF);
    endfunction

    always @(negedge cs_n) begin
        fall_cnt = 0;
        rise_cnt = 0;
        frame_open = 1;
    end

    always @(posedge cs_n) begin
        if (frame_open) begin
            chk(rise_cnt == frame_rises, "R2",
                $sformatf("rising edges in frame %0d expected %0d", rise_cnt, frame_rises));
            frame_open = 0;
        end
    end

    always @(negedge sclk) begin
        if (cs_n === 1'b0) begin
            int pos;
            pos = fall_cnt % 16;
            if (pos == 0) begin
                cur_val = gen(conv_no, conv_ch);
                conv_no++;
            end
            dout = (pos < 4) ? 1'b1 : cur_val[11 - (pos - 4)];
            fall_cnt++;
        end
    end

    always @(posedge sclk) begin
        if (cs_n === 1'b0) begin
            int pos;
            bit want;
            pos = rise_cnt % 16;
            if (pos < 8) ctl = {ctl[6:0], din};
            if (pos == 7) begin
                chk(ctl[4] == 1'b0 && ctl[7:5] == 3'b000 && ctl[2:0] == 3'b000, "R4",
                    $sformatf("control byte %02h expected 00 or 08", ctl));
                want = (exp_addr.size() > 0) ? exp_addr.pop_front() : 1'b0;
                chk(ctl[3] == want, "R5",
                    $sformatf("channel bit %0d expected %0d", ctl[3], want));
                latched = ctl[3];
            end
            if (pos == 15) begin
                exp_res.push_back({conv_ch, cur_val});
                conv_ch = latched;
            end
            rise_cnt++;
        end
    end

    // ---------------- per-clock comparison ----------------
    logic prev_cs = 1'b1, prev_sclk = 1'b1;
    int   hp = 0;
    int   got = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(cs_n && !sclk), "R2", $sformatf("sclk %0d with cs_n high expected 1", sclk));
            if (prev_cs && !cs_n) begin
                hp = 0;
            end else if (!cs_n) begin
                hp++;
                if (sclk != prev_sclk) begin
                    chk(hp == HALF, "R3", $sformatf("half period %0d expected %0d", hp, HALF));
                    hp = 0;
                end
            end
            if (res_valid) begin
                logic [12:0] e;
                got++;
                e = (exp_res.size() > 0) ? exp_res.pop_front() : 13'h1FFF;
                chk(res_data == e[11:0], "R6",
                    $sformatf("res_data %03h expected %03h", res_data, e[11:0]));
                chk(res_chan == e[12], "R7",
                    $sformatf("res_chan %0d expected %0d", res_chan, e[12]));
            end
            if (done) begin
                chk(!busy && cs_n, "R8", $sformatf("busy %0d cs_n %0d expected 0 1", busy, cs_n));
                chk(exp_res.size() == 0, "R6",
                    $sformatf("pending results %0d expected 0", exp_res.size()));
            end
        end
        prev_cs = cs_n;
        prev_sclk = sclk;
    end

    // ---------------- frame driver ----------------
    task automatic run_frame(input logic [2:0] b, input logic [7:0] s, input bit poke);
        int n;
        n = int'(b) + 1;
        for (int j = 0; j < n; j++) exp_addr.push_back(s[j]);
        frame_rises = 16 * n;
        got = 0;
        @(negedge clk);
        start = 1'b1; burst_cnt = b; chan_seq = s;
        @(negedge clk);
        start = 1'b0; burst_cnt = ~b; chan_seq = ~s;
        chk(busy == 1'b1, "R8", $sformatf("busy %0d expected 1", busy));
        if (poke) begin
            repeat (50) @(negedge clk);
            start = 1'b1; burst_cnt = 3'd0; chan_seq = ~s;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(got == n, "R6", $sformatf("results %0d expected %0d", got, n));
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(!busy && cs_n, "R9", $sformatf("busy %0d cs_n %0d after frame expected 0 1", busy, cs_n));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n && sclk && !busy && !done && !res_valid, "R1",
            $sformatf("cs_n %0d sclk %0d busy %0d done %0d valid %0d expected 1 1 0 0 0",
                      cs_n, sclk, busy, done, res_valid));
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && sclk && !busy, "R1", $sformatf("idle after reset cs_n %0d sclk %0d busy %0d", cs_n, sclk, busy));
        run_frame(3'd0, 8'h01, 1'b0);   // first result is channel 1 (R7)
        run_frame(3'd7, 8'b1011_0010, 1'b0);
        run_frame(3'd2, 8'h00, 1'b0);
        run_frame(3'd3, 8'b0000_0101, 1'b1); // start while busy ignored (R9)
        run_frame(3'd1, 8'h03, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule